// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the error bookkeeping of one CAN node and turns it into the node's fault confinement state. The protocol engine sends it single-cycle pulses for the events it has already classified: a transmit error, an acknowledge error, a receive error, a successful transmission and a successful reception. It also sends a strobe with the sampled bus level. The block holds a transmit error counter and a receive error counter. From them it derives a 2-bit state: error active, error passive or bus off. It raises a one-cycle interrupt when the node drops into bus off.

Recovery from bus off needs no extra storage. The transmit counter is reused as the outer stage of a cascade. An inner run-length counter counts consecutive recessive samples, and each complete run of eleven advances the transmit counter. When 128 runs have been seen, the node comes back as error active with both counters at zero. A test-mode write port can load either counter. Outside test mode the counters change only through protocol events.

Every event acts on the clock edge where it is sampled, and the new values appear on the outputs after that edge.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, `fc_state_o` is 00 (error active), both counters read 0 and `busoff_irq_o` is low.
- R2: Outside bus off, each counter event takes effect on the next clock edge. A transmit error or an acknowledge error adds 8 to the transmit counter. A receive error adds 1 to the receive counter. A successful transmission or reception subtracts 1 from its own counter when that counter is nonzero.
- R3: Outside bus off, the state is 01 (error passive) whenever either counter holds 128 or more.
- R4: Outside bus off, the state is 00 (error active) whenever both counters hold 127 or less. A node in error passive therefore returns to error active as soon as the last counter at 128 or above drops to 127 or below.
- R5: A transmit error that would push the transmit counter above 255 does three things on the same edge: the state becomes 10 (bus off), the transmit counter becomes 0, and `busoff_irq_o` is high for exactly that one cycle.
- R6: In bus off, each run of 11 consecutive recessive samples adds 1 to the transmit counter and restarts the run. A sample is a cycle with `bit_smp_i` high, and recessive means `bit_rec_i` = 1. Cycles without a sample do not break a run.
- R7: In bus off, a dominant sample (`bit_rec_i` = 0) restarts the run and leaves the transmit counter unchanged.
- R8: When the transmit counter would reach 128 in bus off, the state becomes 00 and both counters become 0.
- R9: A receive counter at 128 or above does not increment on a receive error. A successful reception while it is at 128 or above loads it with 119.
- R10: Acknowledge errors never move the node into bus off. In error passive they saturate the transmit counter at 255.
- R11: With `test_mode_i` high, `tst_wr_tec_i` loads `tst_data_i` into the transmit counter and `tst_wr_rec_i` loads it into the receive counter. With `test_mode_i` low, both write strobes are ignored.
- R12: In bus off, transmit errors, receive errors, acknowledge errors, successes and test writes are ignored, and the receive counter keeps its value.
- R13: Each counter applies at most one event per cycle, in this priority: test write, then error, then success. Among transmit errors, a transmit error takes precedence over an acknowledge error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error pulse |
| ack_err_i | input | 1 | Acknowledge error pulse |
| rx_err_i | input | 1 | Receive error pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| bit_smp_i | input | 1 | Bus sample strobe |
| bit_rec_i | input | 1 | Sampled bus level, 1 = recessive |
| test_mode_i | input | 1 | Enables the counter write strobes |
| tst_wr_tec_i | input | 1 | Load transmit counter |
| tst_wr_rec_i | input | 1 | Load receive counter |
| tst_data_i | input | CNT_W | Value to load |
| fc_state_o | output | 2 | 00 active, 01 passive, 10 bus off |
| tec_o | output | CNT_W | Transmit error counter |
| rec_o | output | CNT_W | Receive error counter |
| busoff_irq_o | output | 1 | One-cycle pulse on entry to bus off |

## Verification
Some relations are checked on every cycle. Outside bus off, the state must agree with the two counter thresholds. The interrupt must coincide with bus off and a cleared transmit counter, and it must never last two cycles. While in bus off, the receive counter must hold and the transmit counter may step by at most one. A saturated receive counter must never grow, and an acknowledge error in error passive must never lead to bus off. Other behaviour depends on specific event sequences, and only the bench's scenarios can show it. This covers the exact arithmetic of each event and the event priority within a cycle. It also covers the 119 reload, restarting a run after a dominant sample, and the full 128-run recovery back to error active.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_e;
endpackage

// File: rtl/can_fc_runlen.sv
// Counts consecutive recessive samples while enabled; pulses when a run completes.
module can_fc_runlen #(
   parameter int RUN_LEN = 11
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enable_i,
   input  logic smp_i,
   input  logic rec_i,
   output logic run_done_o
);
   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("can_fc_runlen: RUN_LEN must be at least 2");
      end
   endgenerate

   localparam int RUN_W = $clog2(RUN_LEN);
   localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

   logic [RUN_W-1:0] cnt_q, cnt_d;

   assign run_done_o = enable_i && smp_i && rec_i && (cnt_q == LAST);

   always_comb begin
      cnt_d = cnt_q;
      if (!enable_i)        cnt_d = '0;
      else if (smp_i) begin
         if (!rec_i)        cnt_d = '0;
         else if (run_done_o) cnt_d = '0;
         else               cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end
endmodule

// File: rtl/can_fc_rxcnt.sv
// Receive error counter with saturation and reload window.
module can_fc_rxcnt #(
   parameter int CNT_W       = 8,
   parameter int PASSIVE_LIM = 128,
   parameter int RX_RELOAD   = 119
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             freeze_i,
   input  logic             clear_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             err_i,
   input  logic             ok_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o
);
   localparam logic [CNT_W-1:0] LIM    = CNT_W'(PASSIVE_LIM);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RX_RELOAD);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      cnt_nxt_o = cnt_q;
      if (clear_i)           cnt_nxt_o = '0;
      else if (freeze_i)     cnt_nxt_o = cnt_q;
      else if (wr_i)         cnt_nxt_o = wr_data_i;
      else if (err_i) begin
         if (cnt_q < LIM)    cnt_nxt_o = cnt_q + 1'b1;
      end else if (ok_i) begin
         if (cnt_q >= LIM)   cnt_nxt_o = RELOAD;
         else if (cnt_q != '0) cnt_nxt_o = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_nxt_o;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int TX_ERR_STEP  = 8,
   parameter int PASSIVE_LIM  = 128,
   parameter int RX_RELOAD    = 119,
   parameter int RUN_LEN      = 11,
   parameter int RECOVER_RUNS = 128
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tx_err_i,
   input  logic             ack_err_i,
   input  logic             rx_err_i,
   input  logic             tx_ok_i,
   input  logic             rx_ok_i,
   input  logic             bit_smp_i,
   input  logic             bit_rec_i,
   input  logic             test_mode_i,
   input  logic             tst_wr_tec_i,
   input  logic             tst_wr_rec_i,
   input  logic [CNT_W-1:0] tst_data_i,
   output logic [1:0]       fc_state_o,
   output logic [CNT_W-1:0] tec_o,
   output logic [CNT_W-1:0] rec_o,
   output logic             busoff_irq_o
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;
   localparam logic [CNT_W:0]   MAX_W  = (CNT_W+1)'(CNT_MAX);
   localparam logic [CNT_W:0]   STEP_W = (CNT_W+1)'(TX_ERR_STEP);
   localparam logic [CNT_W-1:0] LIM    = CNT_W'(PASSIVE_LIM);
   localparam logic [CNT_W-1:0] RCV_LAST = CNT_W'(RECOVER_RUNS - 1);

   generate
      if (PASSIVE_LIM > CNT_MAX || PASSIVE_LIM < 1) begin : g_bad_lim
         $error("can_fault_conf: PASSIVE_LIM out of counter range");
      end
      if (RX_RELOAD >= PASSIVE_LIM) begin : g_bad_reload
         $error("can_fault_conf: RX_RELOAD must lie below PASSIVE_LIM");
      end
      if (RECOVER_RUNS > CNT_MAX || RECOVER_RUNS < 1) begin : g_bad_runs
         $error("can_fault_conf: RECOVER_RUNS out of counter range");
      end
      if (TX_ERR_STEP < 1 || TX_ERR_STEP > CNT_MAX) begin : g_bad_step
         $error("can_fault_conf: TX_ERR_STEP out of range");
      end
   endgenerate

   fc_state_e        st_q, st_d;
   logic [CNT_W-1:0] tec_q, tec_d;
   logic             irq_q, irq_d;
   logic             busoff, run_done, rec_clear, wr_tec;
   logic [CNT_W-1:0] rec_nxt;
   logic [CNT_W:0]   tx_sum;

   assign busoff = (st_q == FC_BUSOFF);
   assign wr_tec = test_mode_i && tst_wr_tec_i;
   assign tx_sum = {1'b0, tec_q} + STEP_W;

   can_fc_runlen #(.RUN_LEN(RUN_LEN)) u_runlen (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .enable_i   (busoff),
      .smp_i      (bit_smp_i),
      .rec_i      (bit_rec_i),
      .run_done_o (run_done)
   );

   can_fc_rxcnt #(
      .CNT_W       (CNT_W),
      .PASSIVE_LIM (PASSIVE_LIM),
      .RX_RELOAD   (RX_RELOAD)
   ) u_rxcnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .freeze_i  (busoff),
      .clear_i   (rec_clear),
      .wr_i      (test_mode_i && tst_wr_rec_i),
      .wr_data_i (tst_data_i),
      .err_i     (rx_err_i),
      .ok_i      (rx_ok_i),
      .cnt_o     (rec_o),
      .cnt_nxt_o (rec_nxt)
   );

   always_comb begin
      tec_d     = tec_q;
      st_d      = st_q;
      irq_d     = 1'b0;
      rec_clear = 1'b0;
      if (busoff) begin
         if (run_done) begin
            if (tec_q == RCV_LAST) begin
               tec_d     = '0;
               st_d      = FC_ACTIVE;
               rec_clear = 1'b1;
            end else begin
               tec_d = tec_q + 1'b1;
            end
         end
      end else begin
         if (wr_tec) begin
            tec_d = tst_data_i;
         end else if (tx_err_i) begin
            if (tx_sum > MAX_W) begin
               tec_d = '0;
               irq_d = 1'b1;
            end else begin
               tec_d = tx_sum[CNT_W-1:0];
            end
         end else if (ack_err_i) begin
            tec_d = (tx_sum > MAX_W) ? MAX_W[CNT_W-1:0] : tx_sum[CNT_W-1:0];
         end else if (tx_ok_i && tec_q != '0) begin
            tec_d = tec_q - 1'b1;
         end
         if (irq_d)                                   st_d = FC_BUSOFF;
         else if (tec_d >= LIM || rec_nxt >= LIM)     st_d = FC_PASSIVE;
         else                                         st_d = FC_ACTIVE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= FC_ACTIVE;
         tec_q <= '0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         tec_q <= tec_d;
         irq_q <= irq_d;
      end
   end

   assign fc_state_o   = st_q;
   assign tec_o        = tec_q;
   assign busoff_irq_o = irq_q;
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
   parameter int CNT_W       = 8,
   parameter int PASSIVE_LIM = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       fc_state,
   input logic [CNT_W-1:0] tec,
   input logic [CNT_W-1:0] rec,
   input logic             irq,
   input logic             tx_err,
   input logic             ack_err,
   input logic             test_mode
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(PASSIVE_LIM);

   // R5
   irq_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (fc_state == 2'b10 && tec == '0));
   // R5
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R3
   passive_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state != 2'b10 && (tec >= LIM || rec >= LIM)) |-> fc_state == 2'b01);
   // R4
   active_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state != 2'b10 && tec < LIM && rec < LIM) |-> fc_state == 2'b00);
   // R12
   busoff_rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state == 2'b10) |=> ($stable(rec) || rec == '0));
   // R6
   busoff_tec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state == 2'b10) |=> (fc_state != 2'b10 || tec == $past(tec)
                               || {1'b0, tec} == {1'b0, $past(tec)} + 1'b1));
   // R9
   rec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec >= LIM && !test_mode) |=> rec <= $past(rec));
   // R10
   ack_no_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state == 2'b01 && ack_err && !tx_err) |=> fc_state != 2'b10);
endmodule

bind can_fault_conf can_fc_chk #(.CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM)) u_chk (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .fc_state  (fc_state_o),
   .tec       (tec_o),
   .rec       (rec_o),
   .irq       (busoff_irq_o),
   .tx_err    (tx_err_i),
   .ack_err   (ack_err_i),
   .test_mode (test_mode_i)
);

// File: tb/can_fault_conf_bench.sv
module can_fault_conf_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic txe, acke, rxe, txo, rxo, bv, bb, tm, wtx, wrx;
   logic [7:0] d;
   logic [1:0] st;
   logic [7:0] tec, rec;
   logic irq;

   can_fault_conf u_can_fault_conf (
      .clk_i(clk), .rst_ni(rst_n),
      .tx_err_i(txe), .ack_err_i(acke), .rx_err_i(rxe),
      .tx_ok_i(txo), .rx_ok_i(rxo),
      .bit_smp_i(bv), .bit_rec_i(bb),
      .test_mode_i(tm), .tst_wr_tec_i(wtx), .tst_wr_rec_i(wrx),
      .tst_data_i(d),
      .fc_state_o(st), .tec_o(tec), .rec_o(rec), .busoff_irq_o(irq)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   string cur_tag = "R1";
   int m_st = 0, m_tec = 0, m_rec = 0, m_run = 0, m_irq = 0;

   task automatic check(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Expected next state, derived from the requirements.
   task automatic model_step();
      m_irq = 0;
      if (m_st == 2) begin
         if (bv) begin
            if (bb) begin
               if (m_run == 10) begin
                  m_run = 0;
                  if (m_tec == 127) begin m_st = 0; m_tec = 0; m_rec = 0; end
                  else m_tec++;
               end else m_run++;
            end else m_run = 0;
         end
      end else begin
         m_run = 0;
         if (tm && wtx) m_tec = d;
         else if (txe) begin
            if (m_tec + 8 > 255) begin m_tec = 0; m_irq = 1; end
            else m_tec += 8;
         end else if (acke) m_tec = (m_tec + 8 > 255) ? 255 : m_tec + 8;
         else if (txo && m_tec > 0) m_tec--;
         if (tm && wrx) m_rec = d;
         else if (rxe) begin if (m_rec < 128) m_rec++; end
         else if (rxo) begin
            if (m_rec >= 128) m_rec = 119;
            else if (m_rec > 0) m_rec--;
         end
         if (m_irq) m_st = 2;
         else m_st = (m_tec >= 128 || m_rec >= 128) ? 1 : 0;
      end
   endtask

   task automatic cyc(logic a_txe, logic a_acke, logic a_rxe, logic a_txo, logic a_rxo,
                      logic a_bv, logic a_bb, logic a_tm, logic a_wtx, logic a_wrx,
                      logic [7:0] a_d);
      txe = a_txe; acke = a_acke; rxe = a_rxe; txo = a_txo; rxo = a_rxo;
      bv = a_bv; bb = a_bb; tm = a_tm; wtx = a_wtx; wrx = a_wrx; d = a_d;
      model_step();
      @(negedge clk);
      check(cur_tag, st, m_st, "state");
      check(cur_tag, tec, m_tec, "tec");
      check(cur_tag, rec, m_rec, "rec");
      check(cur_tag, irq, m_irq, "irq");
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0,0,0,0,0,8'd0);
   endtask

   initial begin
      void'($urandom(32'h1d5e_a7c3));
      {txe, acke, rxe, txo, rxo, bv, bb, tm, wtx, wrx} = '0;
      d = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      check("R1", st, 0, "state"); check("R1", tec, 0, "tec");
      check("R1", rec, 0, "rec");  check("R1", irq, 0, "irq");
      idle(2);

      // R2 event arithmetic
      cur_tag = "R2";
      cyc(1,0,0,0,0,0,0,0,0,0,0);
      check("R2", tec, 8, "tec after tx error");
      for (int i = 0; i < 3; i++) cyc(0,0,1,0,0,0,0,0,0,0,0);
      cyc(0,0,0,1,1,0,0,0,0,0,0);
      check("R2", tec, 7, "tec after tx ok"); check("R2", rec, 2, "rec after rx ok");

      // R3 entry into error passive
      cur_tag = "R3";
      for (int i = 0; i < 15; i++) cyc(1,0,0,0,0,0,0,0,0,0,0);
      check("R3", st, 0, "state at 127");
      cyc(1,0,0,0,0,0,0,0,0,0,0);
      check("R3", st, 1, "state at 135");

      // R10 acknowledge errors saturate, no bus off
      cur_tag = "R10";
      for (int i = 0; i < 20; i++) cyc(0,1,0,0,0,0,0,0,0,0,0);
      check("R10", tec, 255, "tec saturated"); check("R10", st, 1, "state");

      // R4 return to error active
      cur_tag = "R4";
      for (int i = 0; i < 127; i++) cyc(0,0,0,1,0,0,0,0,0,0,0);
      check("R4", st, 1, "state at 128");
      cyc(0,0,0,1,0,0,0,0,0,0,0);
      check("R4", st, 0, "state at 127");

      // R13 priority inside one cycle
      cur_tag = "R13";
      cyc(1,0,1,0,0,0,0,1,1,1,8'd100);
      check("R13", tec, 100, "write beats tx error"); check("R13", rec, 100, "write beats rx error");
      cyc(1,0,1,1,1,0,0,0,0,0,0);
      check("R13", tec, 108, "error beats success"); check("R13", rec, 101, "error beats success");

      // R11 write strobes need test mode
      cur_tag = "R11";
      cyc(0,0,0,0,0,0,0,0,1,1,8'd3);
      check("R11", tec, 108, "write ignored"); check("R11", rec, 101, "write ignored");
      cyc(0,0,0,0,0,0,0,1,0,1,8'd127);
      check("R11", rec, 127, "rec loaded");

      // R9 receive saturation and reload
      cur_tag = "R9";
      cyc(0,0,1,0,0,0,0,0,0,0,0);
      check("R9", rec, 128, "rec to 128"); check("R9", st, 1, "passive");
      cyc(0,0,1,0,0,0,0,0,0,0,0);
      check("R9", rec, 128, "rec saturated");
      cyc(0,0,0,0,1,0,0,0,0,0,0);
      check("R9", rec, 119, "rec reload"); check("R9", st, 0, "active again");

      // R5 entry into bus off
      cur_tag = "R5";
      cyc(0,0,0,0,0,0,0,1,1,0,8'd250);
      cyc(1,1,0,0,0,0,0,0,0,0,0);
      check("R5", st, 2, "bus off"); check("R5", tec, 0, "tec cleared");
      check("R5", irq, 1, "irq");
      idle(1);
      check("R5", irq, 0, "irq single");

      // R12 events ignored in bus off
      cur_tag = "R12";
      cyc(1,1,1,1,1,0,0,1,1,1,8'd77);
      cyc(0,0,0,0,1,0,0,0,0,0,0);
      check("R12", tec, 0, "tec held"); check("R12", rec, 119, "rec held");
      check("R12", st, 2, "still bus off");

      // R7 dominant sample restarts the run
      cur_tag = "R7";
      for (int i = 0; i < 10; i++) cyc(0,0,0,0,0,1,1,0,0,0,0);
      cyc(0,0,0,0,0,1,0,0,0,0,0);
      for (int i = 0; i < 10; i++) cyc(0,0,0,0,0,1,1,0,0,0,0);
      cyc(0,0,0,0,0,0,0,0,0,0,0);
      check("R7", tec, 0, "no increment");

      // R6 full run counts once
      cur_tag = "R6";
      cyc(0,0,0,0,0,1,1,0,0,0,0);
      check("R6", tec, 1, "tec after run");

      // R8 recovery completes
      cur_tag = "R8";
      for (int i = 0; i < 127 * 11 - 1; i++) cyc(0,0,0,0,0,1,1,0,0,0,0);
      check("R8", st, 2, "one sample short");
      cyc(0,0,0,0,0,1,1,0,0,0,0);
      check("R8", st, 0, "active"); check("R8", tec, 0, "tec"); check("R8", rec, 0, "rec");

      // Random mix, model-checked (R2 R3 R4 R5 R6 R9 R13)
      cur_tag = "R2 random";
      for (int i = 0; i < 30000; i++) begin
         logic r_tm;
         r_tm = ($urandom_range(0, 99) < 3);
         cyc($urandom_range(0, 99) < 30, $urandom_range(0, 99) < 10,
             $urandom_range(0, 99) < 25, $urandom_range(0, 99) < 20,
             $urandom_range(0, 99) < 20, $urandom_range(0, 99) < 70,
             $urandom_range(0, 99) < 97, r_tm, $urandom_range(0, 1) == 1,
             $urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)));
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule